// File: doc/BRIEF.md
# Fault Address Register Bank

This block holds two 32-bit fault address registers for a processor core. The data fault register records the address of a data access that caused a precise abort. The instruction fault register records the address of an instruction fetch that caused a prefetch abort. The core's abort and debug event signals load these registers with no software action. Privileged software or a debugger can also read either register, or write it to restore a saved value.

Software reaches the registers through coprocessor-style requests. Each request carries a primary register number, a secondary register number, an opcode2 selector, a read/write flag and a privilege indication. The block answers every request one cycle later with a response pulse. The response carries read data or an undefined-access flag. A hardware capture and a software write can arrive in the same cycle, so the block uses a fixed priority between its load sources.

Top module: `fault_addr_bank`

## Requirements
- R1: After reset, both registers read as zero and `rsp_valid` is low.
- R2: A request selects the data fault register when primary register = 6, secondary register = 0 and opcode2 = 0. It selects the instruction fault register when the same fields hold 6, 0 and 2.
- R3: Every request gives exactly one `rsp_valid` pulse, on the cycle after the request. A legal privileged write loads `req_wdata` into the selected register. A later read of that register returns the written value.
- R4: A request with `req_priv` low gives `rsp_undef` = 1 and changes neither register.
- R5: A privileged request is undefined (`rsp_undef` = 1) and changes neither register in two cases: its opcode2 is neither 0 nor 2, or its primary or secondary register does not select this bank. Undefined responses and write responses return `rsp_rdata` = 0.
- R6: A pulse on `dabort_valid` loads `dabort_addr` into the data fault register.
- R7: A pulse on `pabort_valid` loads `pabort_addr` into the instruction fault register.
- R8: A pulse on `wpt_entry` loads `wpt_addr` into the data fault register. When `wpt_entry` and `dabort_valid` occur in the same cycle, `dabort_addr` is loaded.
- R9: When a hardware capture and a software write target the same register in the same cycle, the captured address is kept. The write still gets a defined response with `rsp_undef` = 0.
- R10: A read in the same cycle as a capture into the same register returns the value held before that capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_crn | input | 4 | Primary register number |
| req_crm | input | 4 | Secondary register number |
| req_op2 | input | 3 | Opcode2 selector |
| req_priv | input | 1 | Requester is privileged |
| req_wdata | input | 32 | Write data |
| dabort_valid | input | 1 | Precise data abort event |
| dabort_addr | input | 32 | Faulting data address |
| pabort_valid | input | 1 | Prefetch abort event |
| pabort_addr | input | 32 | Faulting instruction address |
| wpt_entry | input | 1 | Debug entry caused by a watchpoint |
| wpt_addr | input | 32 | Data address that hit the watchpoint |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read data |
| rsp_undef | output | 1 | Request was undefined |

## Verification
The bench builds the block with its default parameters: a 32-bit address width, primary register 6, secondary register 0, and opcode2 codes 0 and 2. With these values the bench can write full 32-bit patterns and read them back. It also reaches the unmapped opcode2 codes 1 and 3 and a neighbouring primary register number 5. All capture priority cases are reached on the real decode: data abort against watchpoint, capture against software write, and capture against read in the same cycle.

// File: rtl/fault_addr_bank.sv
module fault_addr_bank #(
  parameter int AW = 32,
  parameter logic [3:0] SEL_CRN = 4'd6,
  parameter logic [3:0] SEL_CRM = 4'd0,
  parameter logic [2:0] OP2_DATA = 3'd0,
  parameter logic [2:0] OP2_INSTR = 3'd2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [3:0]    req_crn,
  input  logic [3:0]    req_crm,
  input  logic [2:0]    req_op2,
  input  logic          req_priv,
  input  logic [AW-1:0] req_wdata,
  input  logic          dabort_valid,
  input  logic [AW-1:0] dabort_addr,
  input  logic          pabort_valid,
  input  logic [AW-1:0] pabort_addr,
  input  logic          wpt_entry,
  input  logic [AW-1:0] wpt_addr,
  output logic          rsp_valid,
  output logic [AW-1:0] rsp_rdata,
  output logic          rsp_undef
);

  logic [AW-1:0] dfa_q, ifa_q, dfa_d, ifa_d;
  logic          bank_hit, sel_d, sel_i, legal;

  assign bank_hit = req_valid && req_priv && req_crn == SEL_CRN && req_crm == SEL_CRM;
  assign sel_d    = bank_hit && req_op2 == OP2_DATA;
  assign sel_i    = bank_hit && req_op2 == OP2_INSTR;
  assign legal    = sel_d || sel_i;

  always_comb begin
    dfa_d = dfa_q;
    if (dabort_valid)            dfa_d = dabort_addr;
    else if (wpt_entry)          dfa_d = wpt_addr;
    else if (sel_d && req_write) dfa_d = req_wdata;
  end

  always_comb begin
    ifa_d = ifa_q;
    if (pabort_valid)            ifa_d = pabort_addr;
    else if (sel_i && req_write) ifa_d = req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dfa_q     <= '0;
      ifa_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_undef <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      dfa_q     <= dfa_d;
      ifa_q     <= ifa_d;
      rsp_valid <= req_valid;
      rsp_undef <= req_valid && !legal;
      rsp_rdata <= (legal && !req_write) ? (sel_d ? dfa_q : ifa_q) : '0;
    end
  end

  // R3: one response per request, one cycle later
  a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R4: unprivileged access is undefined and leaves the registers alone
  a_r4_user_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv) |=> rsp_undef);
  a_r4_user_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_priv && !dabort_valid && !wpt_entry && !pabort_valid)
      |=> ($stable(dfa_q) && $stable(ifa_q)));
  // R5: undefined response carries no data
  a_r5_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_undef) |-> rsp_rdata == '0);
  // R6, R8, R9: data abort capture has top priority
  a_r6_dabort_capture: assert property (@(posedge clk) disable iff (!rst_n)
    dabort_valid |=> dfa_q == $past(dabort_addr));
  // R7, R9: prefetch abort capture has top priority
  a_r7_pabort_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pabort_valid |=> ifa_q == $past(pabort_addr));

endmodule

// File: tb/tb_fault_addr_bank.sv
module tb_fault_addr_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {write, op2[2:0], priv, crn[3:0], wdata[31:0], exp_undef, exp_rdata[31:0]}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 3'd0, 1'b1, 4'd6, 32'h0,         1'b0, 32'h0},          // R1 dfa reset
    {1'b0, 3'd2, 1'b1, 4'd6, 32'h0,         1'b0, 32'h0},          // R1 ifa reset
    {1'b1, 3'd0, 1'b1, 4'd6, 32'h1234_5678, 1'b0, 32'h0},          // R3 write dfa
    {1'b0, 3'd0, 1'b1, 4'd6, 32'h0,         1'b0, 32'h1234_5678},  // R2 R3
    {1'b1, 3'd2, 1'b1, 4'd6, 32'hA5A5_0F0F, 1'b0, 32'h0},          // R3 write ifa
    {1'b0, 3'd2, 1'b1, 4'd6, 32'h0,         1'b0, 32'hA5A5_0F0F},  // R2 R3
    {1'b1, 3'd0, 1'b0, 4'd6, 32'hDEAD_BEEF, 1'b1, 32'h0},          // R4 user write
    {1'b0, 3'd0, 1'b0, 4'd6, 32'h0,         1'b1, 32'h0},          // R4 user read
    {1'b0, 3'd0, 1'b1, 4'd6, 32'h0,         1'b0, 32'h1234_5678},  // R4 unchanged
    {1'b1, 3'd3, 1'b1, 4'd6, 32'h5555_AAAA, 1'b1, 32'h0},          // R5 op2 3
    {1'b1, 3'd2, 1'b1, 4'd5, 32'h7777_7777, 1'b1, 32'h0},          // R5 crn 5
    {1'b0, 3'd2, 1'b1, 4'd6, 32'h0,         1'b0, 32'hA5A5_0F0F}   // R5 unchanged
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_priv = 0;
  logic [3:0] req_crn = 0, req_crm = 0;
  logic [2:0] req_op2 = 0;
  logic [31:0] req_wdata = 0, dabort_addr = 0, pabort_addr = 0, wpt_addr = 0;
  logic dabort_valid = 0, pabort_valid = 0, wpt_entry = 0;
  logic rsp_valid, rsp_undef;
  logic [31:0] rsp_rdata;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_addr_bank dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_crn(req_crn), .req_crm(req_crm), .req_op2(req_op2), .req_priv(req_priv),
    .req_wdata(req_wdata), .dabort_valid(dabort_valid), .dabort_addr(dabort_addr),
    .pabort_valid(pabort_valid), .pabort_addr(pabort_addr), .wpt_entry(wpt_entry),
    .wpt_addr(wpt_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_req(input logic wr, input logic [2:0] op2, input logic priv,
                         input logic [3:0] crn, input logic [31:0] wd);
    req_valid = 1; req_write = wr; req_op2 = op2; req_priv = priv;
    req_crn = crn; req_crm = 4'd0; req_wdata = wd;
  endtask

  // request driven at negedge, response sampled at the following negedge
  task automatic finish_req(input string tag, input logic exp_undef, input logic [31:0] exp_data);
    @(posedge clk); @(negedge clk);
    req_valid = 0; req_write = 0;
    dabort_valid = 0; pabort_valid = 0; wpt_entry = 0;
    check({tag, " valid"}, {31'b0, rsp_valid}, 32'd1);
    check({tag, " undef"}, {31'b0, rsp_undef}, {31'b0, exp_undef});
    check({tag, " data"}, rsp_rdata, exp_data);
  endtask

  task automatic pulse_idle;
    @(posedge clk); @(negedge clk);
    dabort_valid = 0; pabort_valid = 0; wpt_entry = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      set_req(VEC[i][73], VEC[i][72:70], VEC[i][69], VEC[i][68:65], VEC[i][64:33]);
      finish_req($sformatf("vec%0d", i), VEC[i][32], VEC[i][31:0]);
    end

    // R3: idle cycle gives no response
    pulse_idle;
    check("R3 no response when idle", {31'b0, rsp_valid}, 32'd0);

    // R6
    dabort_valid = 1; dabort_addr = 32'h0000_BAD0; pulse_idle;
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R6 dabort capture", 0, 32'h0000_BAD0);

    // R7
    pabort_valid = 1; pabort_addr = 32'hF00D_0004; pulse_idle;
    set_req(0, 3'd2, 1, 4'd6, 0); finish_req("R7 pabort capture", 0, 32'hF00D_0004);

    // R8 watchpoint alone
    wpt_entry = 1; wpt_addr = 32'h2000_0010; pulse_idle;
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R8 watchpoint capture", 0, 32'h2000_0010);

    // R8 data abort beats watchpoint
    wpt_entry = 1; wpt_addr = 32'h3333_3333;
    dabort_valid = 1; dabort_addr = 32'h4444_4444; pulse_idle;
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R8 dabort over watchpoint", 0, 32'h4444_4444);

    // R9 capture beats software write, data register
    dabort_valid = 1; dabort_addr = 32'h9999_0000;
    set_req(1, 3'd0, 1, 4'd6, 32'h1111_1111); finish_req("R9 write response", 0, 32'h0);
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R9 dabort over write", 0, 32'h9999_0000);

    // R9 capture beats software write, instruction register
    pabort_valid = 1; pabort_addr = 32'h8888_0008;
    set_req(1, 3'd2, 1, 4'd6, 32'h2222_2222); finish_req("R9 write response ifa", 0, 32'h0);
    set_req(0, 3'd2, 1, 4'd6, 0); finish_req("R9 pabort over write", 0, 32'h8888_0008);

    // R10 read during capture returns old value, then new
    pabort_valid = 1; pabort_addr = 32'hCAFE_0100;
    set_req(0, 3'd2, 1, 4'd6, 0); finish_req("R10 read old during capture", 0, 32'h8888_0008);
    set_req(0, 3'd2, 1, 4'd6, 0); finish_req("R10 read new after capture", 0, 32'hCAFE_0100);

    // R5: unmapped op2 1 and foreign secondary register
    set_req(0, 3'd1, 1, 4'd6, 0); finish_req("R5 op2 1 undef", 1, 32'h0);
    set_req(1, 3'd0, 1, 4'd6, 32'h6666_6666); req_crm = 4'd1;
    finish_req("R5 crm 1 undef", 1, 32'h0);
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R5 dfa unchanged", 0, 32'h9999_0000);

    // R1: reset clears both registers
    rst_n = 0; @(posedge clk); @(negedge clk); rst_n = 1;
    check("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'd0);
    set_req(0, 3'd0, 1, 4'd6, 0); finish_req("R1 dfa cleared", 0, 32'h0);
    set_req(0, 3'd2, 1, 4'd6, 0); finish_req("R1 ifa cleared", 0, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule